// File: doc/BRIEF.md
# Stack Pointer and Stack Address Generator

This block keeps the stack pointer of a small multicycle processor and turns each stack operation into a data-memory word address and a pointer update. The pointer always names the first free word of the stack. The stack grows toward lower addresses, and one entry is exactly one word. A push-type operation (register push, or a call saving its return address) writes at the pointer and then moves the pointer down by one. A pop-type operation (register pop, or a return restoring the program counter) reads at pointer plus one and then moves the pointer up by one.

The control sequencer presents an operation code for the whole instruction. The address output follows that code combinationally, so it stays stable for as many memory-access cycles as the sequencer needs. The pointer register changes only in the cycle in which the sequencer raises the commit strobe. This block does not choose the data to write and does not route the value that is read back.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is held (rst_n low) and after it is released, the pointer reads the top-of-stack word, which is 2^MEM_AW - 1, zero-extended to PTR_W bits.
- R2: For a push-type code (PUSH = 3'b001, CALL = 3'b011), the stack address equals the current pointer.
- R3: For a pop-type code (POP = 3'b010, RET = 3'b100), the stack address equals the current pointer plus one.
- R4: A push-type code with commit high at a rising edge leaves the pointer one lower after that edge.
- R5: A pop-type code with commit high at a rising edge leaves the pointer one higher after that edge.
- R6: With commit low, the pointer does not change, whatever code is applied.
- R7: With commit high and code NONE (3'b000) or any unused code (3'b101 to 3'b111), the pointer does not change and stack_op is low.
- R8: CALL gives the same address and the same pointer update as PUSH, and RET gives the same as POP.
- R9: A committed push followed by a committed pop returns the pointer to its earlier value, and both operations use the same address.
- R10: stack_op is high for exactly the four stack codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Stack operation code |
| commit | input | 1 | Pointer update strobe from the sequencer |
| stack_addr | output | PTR_W | Data-memory word address for the operation |
| stack_op | output | 1 | High when op is a stack operation |
| sp | output | PTR_W | Current stack pointer |

## Verification
The bench builds the unit with MEM_AW = 4, so the top of stack is word 15 and the whole sixteen-word region fits in a short run. This lets it push until the pointer has walked below every word of the region, then pop all the way back, and compare each pop address with the address of the matching push. The same setting keeps every expected pointer value small enough to compute directly in the bench.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int PTR_W  = 32,
  parameter int MEM_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic             commit,
  output logic [PTR_W-1:0] stack_addr,
  output logic             stack_op,
  output logic [PTR_W-1:0] sp
);

  localparam logic [2:0] OP_PUSH = 3'b001;
  localparam logic [2:0] OP_POP  = 3'b010;
  localparam logic [2:0] OP_CALL = 3'b011;
  localparam logic [2:0] OP_RET  = 3'b100;
  localparam logic [PTR_W-1:0] TOP_ADDR = {{(PTR_W-MEM_AW){1'b0}}, {MEM_AW{1'b1}}};

  logic is_push, is_pop;
  logic [PTR_W-1:0] sp_r, sp_up;

  assign is_push    = (op == OP_PUSH) || (op == OP_CALL);
  assign is_pop     = (op == OP_POP)  || (op == OP_RET);
  assign stack_op   = is_push || is_pop;
  assign sp_up      = sp_r + PTR_W'(1);
  assign stack_addr = is_pop ? sp_up : sp_r;
  assign sp         = sp_r;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sp_r <= TOP_ADDR;
    else if (commit && is_push)
      sp_r <= sp_r - PTR_W'(1);
    else if (commit && is_pop)
      sp_r <= sp_up;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sp));
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (op == OP_PUSH || op == OP_CALL)) |=> (sp == $past(sp) - PTR_W'(1)));
  p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (op == OP_POP || op == OP_RET)) |=> (sp == $past(sp) + PTR_W'(1)));
  p_push_at_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (op == OP_PUSH || op == OP_CALL)) |=> (sp + PTR_W'(1) == $past(stack_addr)));
  p_pop_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (op == OP_POP || op == OP_RET)) |=> (sp == $past(stack_addr)));
  p_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !stack_op) |=> $stable(sp));

endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  localparam int PTR_W = 32;
  localparam int MEM_AW = 4;
  localparam logic [PTR_W-1:0] TOP = 32'd15;

  logic clk = 1'b0, rst_n = 1'b0, commit = 1'b0;
  logic [2:0] op = 3'b000;
  logic [PTR_W-1:0] stack_addr, sp;
  logic stack_op;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  stack_ptr_unit #(.PTR_W(PTR_W), .MEM_AW(MEM_AW)) i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .commit(commit),
    .stack_addr(stack_addr), .stack_op(stack_op), .sp(sp));

  task automatic check(string req, logic [PTR_W-1:0] act, logic [PTR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // apply op at negedge, sample address, then let one edge pass
  task automatic step(logic [2:0] o, logic c, output logic [PTR_W-1:0] a, output logic f);
    @(negedge clk);
    op = o; commit = c;
    #1; a = stack_addr; f = stack_op;
    @(posedge clk); #1;
    commit = 1'b0; op = 3'b000;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R1 during reset", sp, TOP);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release", sp, TOP);
  endtask

  task automatic t_push_pop(logic [2:0] pu, logic [2:0] po, string tag);
    logic [PTR_W-1:0] s0, a1, a2; logic f;
    s0 = sp;
    step(pu, 1'b1, a1, f);
    check({tag, " R2 push addr"}, a1, s0);
    check({tag, " R4 dec"}, sp, s0 - 1);
    check({tag, " R10 flag push"}, {31'd0, f}, 1);
    step(po, 1'b1, a2, f);
    check({tag, " R3 pop addr"}, a2, s0);
    check({tag, " R5 inc"}, sp, s0);
    check({tag, " R9 same addr"}, a2, a1);
    check({tag, " R10 flag pop"}, {31'd0, f}, 1);
  endtask

  task automatic t_no_commit;
    logic [PTR_W-1:0] s0, a; logic f;
    s0 = sp;
    for (int k = 0; k < 8; k++) begin
      step(3'(k), 1'b0, a, f);
      check("R6 hold without commit", sp, s0);
    end
    step(3'b010, 1'b0, a, f);
    check("R3 pop addr uncommitted", a, s0 + 1);
  endtask

  task automatic t_unused;
    logic [PTR_W-1:0] s0, a; logic f;
    s0 = sp;
    for (int k = 0; k < 8; k++) begin
      if (k == 0 || k > 4) begin
        step(3'(k), 1'b1, a, f);
        check("R7 nop keeps sp", sp, s0);
        check("R7 R10 flag low", {31'd0, f}, 0);
      end
    end
  endtask

  task automatic t_fill_drain;
    logic [PTR_W-1:0] pa [16];
    logic [PTR_W-1:0] a; logic f;
    for (int k = 0; k < 16; k++) begin
      step(k[0] ? 3'b011 : 3'b001, 1'b1, a, f);
      pa[k] = a;
      check("R2 fill addr", a, TOP - PTR_W'(k));
    end
    check("R4 fully pushed", sp, TOP - 16);
    for (int k = 15; k >= 0; k--) begin
      step(k[0] ? 3'b100 : 3'b010, 1'b1, a, f);
      check("R9 LIFO addr match", a, pa[k]);
    end
    check("R5 drained to top", sp, TOP);
  endtask

  initial begin
    t_reset();
    t_push_pop(3'b001, 3'b010, "PUSH/POP");
    t_push_pop(3'b011, 3'b100, "R8 CALL/RET");
    t_push_pop(3'b001, 3'b100, "R8 PUSH/RET");
    t_no_commit();
    t_unused();
    t_fill_drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule